// File: doc/BRIEF.md
# Event-Synchronous Monitoring Snapshot Unit

This block sits beside one stage of a trigger processing pipeline and keeps its live statistics. It counts arriving events, events that were handled to completion and events that ended in error. It also keeps one pass counter and one fail counter for every filter bit of the stage's decision. A free-running tick counter stamps every processing start and stop into a small circular history. From that history the host can rebuild the distribution of processing times, including its tail.

Upstream logic marks roughly one event every few seconds with a monitoring qualifier. When the stage reports that such an event has been handled, the unit copies every live counter, the current buffer occupancies and the history write pointer into a holding set in one cycle. The copy is stamped with that event's number. The copy is taken whether the event completed or was aborted. Every stage in the chain captures on the same event, so their event counts agree exactly. The host reads the held set at leisure and acknowledges it. Meanwhile the live counters keep running. A second flagged event that arrives before the acknowledge is flagged as an overrun, and it does not disturb the held data.

Top module: `mon_snapshot_unit`

## Requirements
- R1: Each cycle with `evt_in` high adds one to the events-in counter.
- R2: A completion (`done_vld`) with `done_err` low adds one to the processed counter. For each filter bit i it also adds one to pass counter i when `done_pass[i]` is 1, or to fail counter i when it is 0. A completion with `done_err` high adds one to the error counter only and leaves every pass and fail counter unchanged.
- R3: A completion with `done_mon` high loads the holding set in that cycle when it is free. From the next cycle `snap_valid` is 1 and `snap_evnum` equals `done_evnum`. The held counts include that completion and any `evt_in` in the same cycle.
- R4: The capture of R3 also happens when the flagged completion has `done_err` high.
- R5: The held occupancies equal `occ_in`, `occ_out` and `occ_rx` as driven in the capture cycle. Receiver j sits at bits [j*OCC_W +: OCC_W].
- R6: While `snap_valid` is 1 and no acknowledge is given, every held field stays unchanged, and the live counters keep counting.
- R7: A flagged completion that arrives while the holding set is full and not acknowledged in that cycle sets `snap_overrun` and is not captured. `host_ack` clears `snap_valid` and `snap_overrun`. A flagged completion in the same cycle as `host_ack` is captured, and `snap_overrun` is 0 afterwards.
- R8: Each cycle with `proc_start` or `proc_stop` high writes one history entry at `ring_wptr` holding the current tick and a kind bit (1 = stop, 0 = start). `ring_wptr` then advances modulo RING_DEPTH (16), so the oldest entry is overwritten on wrap. When both are high in one cycle, one entry of kind stop is written.
- R9: The tick counter is 0 during reset and grows by one every cycle after it. `now_tick` shows it, and the start and stop entries share it.
- R10: After reset every counter, `snap_valid`, `snap_overrun`, `ring_wptr` and every history entry are zero.
- R11: `snap_wptr` holds the value `ring_wptr` had in the capture cycle.
- R12: `ring_rd_stop` and `ring_rd_tick` show, in the same cycle, the history entry selected by `ring_rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | An event entered the stage |
| done_vld | input | 1 | The stage finished handling an event |
| done_err | input | 1 | The finished event ended in error |
| done_mon | input | 1 | The finished event carries the monitoring qualifier |
| done_evnum | input | EVN_W | Event number of the finished event |
| done_pass | input | N_FILT | Per-filter pass (1) or fail (0) result |
| occ_in | input | OCC_W | Input buffer occupancy |
| occ_out | input | OCC_W | Output buffer occupancy |
| occ_rx | input | N_RX*OCC_W | Receiver buffer occupancies |
| proc_start | input | 1 | Processing started |
| proc_stop | input | 1 | Processing stopped |
| ring_rd_idx | input | RPTR_W | History entry to read |
| ring_rd_stop | output | 1 | Kind bit of the selected entry |
| ring_rd_tick | output | TICK_W | Timestamp of the selected entry |
| ring_wptr | output | RPTR_W | Next history slot to write |
| now_tick | output | TICK_W | Current tick count |
| host_ack | input | 1 | Host has read the held snapshot |
| snap_valid | output | 1 | Held snapshot present |
| snap_overrun | output | 1 | A flagged event was lost while holding |
| snap_evnum | output | EVN_W | Event number of the held snapshot |
| snap_n_in | output | CNT_W | Held events-in count |
| snap_n_proc | output | CNT_W | Held processed count |
| snap_n_err | output | CNT_W | Held error count |
| snap_pass | output | N_FILT*CNT_W | Held pass counts, filter i at [i*CNT_W +: CNT_W] |
| snap_fail | output | N_FILT*CNT_W | Held fail counts, same layout |
| snap_occ_in | output | OCC_W | Held input buffer occupancy |
| snap_occ_out | output | OCC_W | Held output buffer occupancy |
| snap_occ_rx | output | N_RX*OCC_W | Held receiver occupancies |
| snap_wptr | output | RPTR_W | Held history write pointer |

## Verification
On every cycle the assertions check these properties: the tick and the history pointer step by exactly one; an errored completion leaves the filter counters untouched; held data stays fixed while it waits for the host; an overrun never appears without a held snapshot; and a free flagged completion always produces a held copy stamped with its number. Only the bench scenarios can show that the held counts are arithmetically right after a sweep of every filter pass pattern. They also show that the occupancies and the pointer come from the capture cycle, that a wrapped history keeps the newest sixteen entries with the right kinds and ticks, and how the acknowledge and overrun interact.

// File: rtl/mon_snap_pkg.sv
package mon_snap_pkg;

    parameter int CNT_W  = 16;
    parameter int EVN_W  = 16;
    parameter int OCC_W  = 5;
    parameter int TICK_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t n_in;
        cnt_t n_proc;
        cnt_t n_err;
    } evt_cnt_t;

    typedef struct packed {
        logic              is_stop;
        logic [TICK_W-1:0] tick;
    } ts_rec_t;

    typedef enum logic {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } hold_state_e;

    function automatic cnt_t cnt_bump(input cnt_t v, input logic en);
        return v + {{(CNT_W-1){1'b0}}, en};
    endfunction

endpackage

// File: rtl/mon_evt_counters.sv
module mon_evt_counters
    import mon_snap_pkg::*;
#(
    parameter int N_FILT = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          evt_in,
    input  logic                          done_vld,
    input  logic                          done_err,
    input  logic [N_FILT-1:0]             done_pass,
    output evt_cnt_t                      cnt_d,
    output logic [N_FILT-1:0][CNT_W-1:0]  pass_d,
    output logic [N_FILT-1:0][CNT_W-1:0]  fail_d
);

    evt_cnt_t                     cnt_q;
    logic [N_FILT-1:0][CNT_W-1:0] pass_q;
    logic [N_FILT-1:0][CNT_W-1:0] fail_q;
    logic                         good_done;

    assign good_done = done_vld & ~done_err;

    always_comb begin
        cnt_d        = cnt_q;
        cnt_d.n_in   = cnt_bump(cnt_q.n_in, evt_in);
        cnt_d.n_proc = cnt_bump(cnt_q.n_proc, good_done);
        cnt_d.n_err  = cnt_bump(cnt_q.n_err, done_vld & done_err);
    end

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        assign pass_d[g] = cnt_bump(pass_q[g], good_done &  done_pass[g]);
        assign fail_d[g] = cnt_bump(fail_q[g], good_done & ~done_pass[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pass_q[g] <= '0;
                fail_q[g] <= '0;
            end else begin
                pass_q[g] <= pass_d[g];
                fail_q[g] <= fail_d[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R1: events-in moves by at most one per cycle, exactly one on evt_in
    p_in_step_r1: assert property (@(posedge clk) disable iff (rst)
        evt_in |=> cnt_q.n_in == $past(cnt_q.n_in) + 1'b1);

    // R2: an errored completion never touches the filter counters
    p_err_no_filter_r2: assert property (@(posedge clk) disable iff (rst)
        (done_vld && done_err) |=> (pass_q == $past(pass_q)) && (fail_q == $past(fail_q)));

    // R2: an errored completion bumps the error count
    p_err_count_r2: assert property (@(posedge clk) disable iff (rst)
        (done_vld && done_err) |=> cnt_q.n_err == $past(cnt_q.n_err) + 1'b1);

endmodule

// File: rtl/mon_ts_ring.sv
module mon_ts_ring
    import mon_snap_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    localparam int RPTR_W    = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_start,
    input  logic              rec_stop,
    input  logic [RPTR_W-1:0] rd_idx,
    output ts_rec_t           rd_rec,
    output logic [RPTR_W-1:0] wptr,
    output logic [TICK_W-1:0] tick
);

    localparam logic [RPTR_W-1:0] LAST_SLOT = RPTR_W'(RING_DEPTH - 1);

    ts_rec_t           mem [RING_DEPTH];
    logic [RPTR_W-1:0] wptr_q;
    logic [TICK_W-1:0] tick_q;
    logic              wr_en;
    ts_rec_t           wr_rec;

    function automatic logic [RPTR_W-1:0] ptr_next(input logic [RPTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign wr_en          = rec_start | rec_stop;
    assign wr_rec.is_stop = rec_stop;
    assign wr_rec.tick    = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            wptr_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (wr_en) wptr_q <= ptr_next(wptr_q);
        end
    end

    for (genvar s = 0; s < RING_DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                    mem[s] <= '0;
            else if (wr_en && wptr_q == RPTR_W'(s))     mem[s] <= wr_rec;
        end
    end

    assign rd_rec = mem[rd_idx];
    assign wptr   = wptr_q;
    assign tick   = tick_q;

    // R9: the tick advances by one every cycle out of reset
    p_tick_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tick_q == $past(tick_q) + 1'b1);

    // R8: one record advances the pointer by one slot, with wrap
    p_wptr_adv_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wptr_q == ptr_next($past(wptr_q)));

    // R8: no record, no pointer movement
    p_wptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wptr_q));

endmodule

// File: rtl/mon_snap_hold.sv
module mon_snap_hold
    import mon_snap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         ack,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic         overrun,
    output logic [W-1:0] dout
);

    hold_state_e state_q;
    logic        ovr_q;
    logic [W-1:0] data_q;
    logic        busy;
    logic        load;

    assign busy = (state_q == SNAP_HELD) & ~ack;
    assign load = capture & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SNAP_EMPTY;
            ovr_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (load) begin
                data_q  <= din;
                state_q <= SNAP_HELD;
            end else if (ack) begin
                state_q <= SNAP_EMPTY;
            end
            ovr_q <= (ovr_q & ~ack) | (capture & busy);
        end
    end

    assign valid   = (state_q == SNAP_HELD);
    assign overrun = ovr_q;
    assign dout    = data_q;

    // R6: held data is frozen while it waits for the host
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> $stable(data_q) && valid);

    // R7: an overrun is only reported alongside a held snapshot
    p_ovr_implies_valid_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> valid);

    // R7: a plain acknowledge empties the holding set
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && !capture) |=> !valid && !overrun);

endmodule

// File: rtl/mon_snapshot_unit.sv
module mon_snapshot_unit
    import mon_snap_pkg::*;
#(
    parameter int N_FILT     = 4,
    parameter int N_RX       = 2,
    parameter int RING_DEPTH = 16,
    localparam int RPTR_W    = $clog2(RING_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     evt_in,
    input  logic                     done_vld,
    input  logic                     done_err,
    input  logic                     done_mon,
    input  logic [EVN_W-1:0]         done_evnum,
    input  logic [N_FILT-1:0]        done_pass,
    input  logic [OCC_W-1:0]         occ_in,
    input  logic [OCC_W-1:0]         occ_out,
    input  logic [N_RX*OCC_W-1:0]    occ_rx,
    input  logic                     proc_start,
    input  logic                     proc_stop,
    input  logic [RPTR_W-1:0]        ring_rd_idx,
    output logic                     ring_rd_stop,
    output logic [TICK_W-1:0]        ring_rd_tick,
    output logic [RPTR_W-1:0]        ring_wptr,
    output logic [TICK_W-1:0]        now_tick,
    input  logic                     host_ack,
    output logic                     snap_valid,
    output logic                     snap_overrun,
    output logic [EVN_W-1:0]         snap_evnum,
    output logic [CNT_W-1:0]         snap_n_in,
    output logic [CNT_W-1:0]         snap_n_proc,
    output logic [CNT_W-1:0]         snap_n_err,
    output logic [N_FILT*CNT_W-1:0]  snap_pass,
    output logic [N_FILT*CNT_W-1:0]  snap_fail,
    output logic [OCC_W-1:0]         snap_occ_in,
    output logic [OCC_W-1:0]         snap_occ_out,
    output logic [N_RX*OCC_W-1:0]    snap_occ_rx,
    output logic [RPTR_W-1:0]        snap_wptr
);

    localparam int SNAP_W = EVN_W + 3*CNT_W + 2*N_FILT*CNT_W + (2 + N_RX)*OCC_W + RPTR_W;

    evt_cnt_t                     cnt_d;
    logic [N_FILT-1:0][CNT_W-1:0] pass_d;
    logic [N_FILT-1:0][CNT_W-1:0] fail_d;
    ts_rec_t                      rd_rec;
    logic [SNAP_W-1:0]            live_vec;
    logic [SNAP_W-1:0]            held_vec;
    logic                         capture;

    mon_evt_counters #(.N_FILT(N_FILT)) u_counters (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (evt_in),
        .done_vld  (done_vld),
        .done_err  (done_err),
        .done_pass (done_pass),
        .cnt_d     (cnt_d),
        .pass_d    (pass_d),
        .fail_d    (fail_d)
    );

    mon_ts_ring #(.RING_DEPTH(RING_DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .rec_start (proc_start),
        .rec_stop  (proc_stop),
        .rd_idx    (ring_rd_idx),
        .rd_rec    (rd_rec),
        .wptr      (ring_wptr),
        .tick      (now_tick)
    );

    assign ring_rd_stop = rd_rec.is_stop;
    assign ring_rd_tick = rd_rec.tick;

    assign capture  = done_vld & done_mon;
    assign live_vec = {done_evnum, cnt_d.n_in, cnt_d.n_proc, cnt_d.n_err,
                       pass_d, fail_d, occ_in, occ_out, occ_rx, ring_wptr};

    mon_snap_hold #(.W(SNAP_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .ack     (host_ack),
        .din     (live_vec),
        .valid   (snap_valid),
        .overrun (snap_overrun),
        .dout    (held_vec)
    );

    assign {snap_evnum, snap_n_in, snap_n_proc, snap_n_err, snap_pass, snap_fail,
            snap_occ_in, snap_occ_out, snap_occ_rx, snap_wptr} = held_vec;

    // R3: a free flagged completion yields a held copy stamped with its number
    p_capture_stamp_r3: assert property (@(posedge clk) disable iff (rst)
        (capture && !(snap_valid && !host_ack)) |=> snap_valid && snap_evnum == $past(done_evnum));

    // R11: the held pointer is the history pointer of the capture cycle
    p_capture_wptr_r11: assert property (@(posedge clk) disable iff (rst)
        (capture && !(snap_valid && !host_ack)) |=> snap_wptr == $past(ring_wptr));

endmodule

// File: tb/mon_snapshot_unit_tb.sv
module mon_snapshot_unit_tb;
    import mon_snap_pkg::*;

    localparam int NF = 4;
    localparam int NR = 2;
    localparam int RD = 16;

    logic clk = 1'b0;
    logic rst;
    logic evt_in, done_vld, done_err, done_mon, proc_start, proc_stop, host_ack;
    logic [EVN_W-1:0] done_evnum;
    logic [NF-1:0] done_pass;
    logic [OCC_W-1:0] occ_in, occ_out;
    logic [NR*OCC_W-1:0] occ_rx;
    logic [3:0] ring_rd_idx;
    logic ring_rd_stop;
    logic [TICK_W-1:0] ring_rd_tick, now_tick;
    logic [3:0] ring_wptr, snap_wptr;
    logic snap_valid, snap_overrun;
    logic [EVN_W-1:0] snap_evnum;
    logic [CNT_W-1:0] snap_n_in, snap_n_proc, snap_n_err;
    logic [NF*CNT_W-1:0] snap_pass, snap_fail;
    logic [OCC_W-1:0] snap_occ_in, snap_occ_out;
    logic [NR*OCC_W-1:0] snap_occ_rx;

    always #4 clk = ~clk;

    mon_snapshot_unit #(.N_FILT(NF), .N_RX(NR), .RING_DEPTH(RD)) u_dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    int m_in = 0, m_proc = 0, m_err = 0, m_wptr = 0;
    int m_pass [NF];
    int m_fail [NF];
    bit m_valid = 0, m_ovr = 0;
    int e_evn, e_in, e_proc, e_err, e_occi, e_occo, e_occr, e_wptr;
    int e_pass [NF];
    int e_fail [NF];
    int r_kind [RD];
    longint r_tick [RD];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic evt(input bit in, input bit dv, input bit err, input bit mon,
                       input int evn, input int pass, input int oi, input int oo,
                       input int orx, input bit ack);
        @(negedge clk);
        evt_in = in; done_vld = dv; done_err = err; done_mon = mon;
        done_evnum = EVN_W'(evn); done_pass = NF'(pass);
        occ_in = OCC_W'(oi); occ_out = OCC_W'(oo); occ_rx = (NR*OCC_W)'(orx);
        host_ack = ack;
        if (in) m_in++;
        if (dv) begin
            if (err) m_err++;
            else begin
                m_proc++;
                for (int i = 0; i < NF; i++)
                    if (pass[i]) m_pass[i]++; else m_fail[i]++;
            end
        end
        if (dv && mon) begin
            if (!m_valid || ack) begin
                e_evn = evn; e_in = m_in; e_proc = m_proc; e_err = m_err;
                e_occi = oi; e_occo = oo; e_occr = orx; e_wptr = m_wptr;
                for (int i = 0; i < NF; i++) begin
                    e_pass[i] = m_pass[i]; e_fail[i] = m_fail[i];
                end
                m_valid = 1; m_ovr = 0;
            end else m_ovr = 1;
        end else if (ack) begin
            m_valid = 0; m_ovr = 0;
        end
        @(negedge clk);
        evt_in = 0; done_vld = 0; done_err = 0; done_mon = 0; host_ack = 0;
    endtask

    task automatic rec(input bit st, input bit sp, input int gap);
        @(negedge clk);
        proc_start = st; proc_stop = sp;
        if (st || sp) begin
            r_kind[m_wptr] = sp;
            r_tick[m_wptr] = longint'(now_tick);
            m_wptr = (m_wptr + 1) % RD;
        end
        @(negedge clk);
        proc_start = 0; proc_stop = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_snap(input string req);
        check({req, " valid"}, 64'(snap_valid), 64'(m_valid));
        check({req, " overrun"}, 64'(snap_overrun), 64'(m_ovr));
        check({req, " evnum"}, 64'(snap_evnum), 64'(e_evn));
        check({req, " R1 n_in"}, 64'(snap_n_in), 64'(e_in));
        check({req, " R2 n_proc"}, 64'(snap_n_proc), 64'(e_proc));
        check({req, " R2 n_err"}, 64'(snap_n_err), 64'(e_err));
        for (int i = 0; i < NF; i++) begin
            check({req, " R2 pass"}, 64'(snap_pass[i*CNT_W +: CNT_W]), 64'(e_pass[i]));
            check({req, " R2 fail"}, 64'(snap_fail[i*CNT_W +: CNT_W]), 64'(e_fail[i]));
        end
        check({req, " R5 occ_in"}, 64'(snap_occ_in), 64'(e_occi));
        check({req, " R5 occ_out"}, 64'(snap_occ_out), 64'(e_occo));
        check({req, " R5 occ_rx"}, 64'(snap_occ_rx), 64'(e_occr));
        check({req, " R11 wptr"}, 64'(snap_wptr), 64'(e_wptr));
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin m_pass[i] = 0; m_fail[i] = 0; end
        rst = 1; evt_in = 0; done_vld = 0; done_err = 0; done_mon = 0;
        done_evnum = '0; done_pass = '0; occ_in = '0; occ_out = '0; occ_rx = '0;
        proc_start = 0; proc_stop = 0; host_ack = 0; ring_rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        check("R10 valid", 64'(snap_valid), 0);
        check("R10 overrun", 64'(snap_overrun), 0);
        check("R10 wptr", 64'(ring_wptr), 0);
        check("R10 snap_n_in", 64'(snap_n_in), 0);
        check("R10 ring tick", 64'(ring_rd_tick), 0);
        check("R9 tick at reset", 64'(now_tick), 0);
        repeat (5) @(negedge clk);
        check("R9 tick after 5", 64'(now_tick), 5);

        // R1 R2 sweep of every pass pattern, plus errors and bare arrivals
        for (int p = 0; p < 16; p++) evt(1, 1, 0, 0, 0, p, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) evt(1, 1, 1, 0, 0, 4'hF, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) evt(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3 no capture yet", 64'(snap_valid), 0);
        // R3 R5 flagged completion, with an arrival in the same cycle
        evt(1, 1, 0, 1, 16'h1234, 4'b1010, 7, 19, 10'h2A5, 0);
        check_snap("R3");

        // R6 live counters keep running; held data frozen
        for (int k = 0; k < 4; k++) evt(1, 1, k[0], 0, 0, 4'b0110, 1, 1, 1, 0);
        check_snap("R6");
        // R7 flagged completion while held: overrun, data kept
        evt(0, 1, 0, 1, 16'h5555, 4'b0001, 3, 3, 3, 0);
        check_snap("R7 overrun");
        check("R7 overrun set", 64'(snap_overrun), 1);
        // R7 acknowledge clears
        evt(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R7 ack valid", 64'(snap_valid), 0);
        check("R7 ack overrun", 64'(snap_overrun), 0);

        // R4 flagged completion in error is still captured
        evt(1, 1, 1, 1, 16'h0BAD, 4'b1111, 2, 4, 10'h3FF, 0);
        check_snap("R4");
        // R7 flagged completion with simultaneous ack is captured
        evt(1, 1, 0, 1, 16'hBEEF, 4'b0101, 31, 0, 10'h001, 1);
        check_snap("R7 ack+capture");

        // R8 R9 history: 20 records with uneven gaps, one simultaneous pair
        for (int k = 0; k < 20; k++) begin
            if (k == 13) rec(1, 1, k % 3);
            else         rec(k[0] == 0, k[0] == 1, k % 4);
        end
        check("R8 wptr wrap", 64'(ring_wptr), 64'(m_wptr));
        for (int i = 0; i < RD; i++) begin
            ring_rd_idx = 4'(i);
            #1;
            check("R12 R8 kind", 64'(ring_rd_stop), 64'(r_kind[i]));
            check("R12 R9 tick", 64'(ring_rd_tick), 64'(r_tick[i]));
        end

        // R11 capture after history writes records the pointer
        evt(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        rec(1, 0, 0);
        evt(0, 1, 0, 1, 16'h0042, 4'b0011, 5, 6, 10'h0C3, 0);
        check_snap("R11");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule